// File: doc/BRIEF.md
# Device Error Classification and Signaling

This block sits in a link endpoint beside the logic that detects protocol and data errors. Each cycle it can accept one detected error event, described by a status vector that should name a single error type, a class bit (correctable or uncorrectable), a flag marking the event as a candidate for advisory handling, and a 16-bit source ID. It decides whether the event is legal and what severity it has. It then updates the sticky status registers and chooses between reporting the event and keeping it quiet. When reporting is allowed it emits one error message that carries a one-hot severity and the source ID.

The block keeps the per-type masks, the uncorrectable severity selection, a summary of detected error classes and the report-enable bits. Software reaches all of them through a simple register write port. Capture of header logs is handled elsewhere. This block only pulses a record request with the error's status bit, and the log keeper answers in the same cycle with an overflow indication. An overflow causes the block to raise a header-log-overflow event of its own later.

Top module: `err_signal`

## Requirements
- R1: An event is legal only if its status, ANDed with the supported set for its class, has exactly one bit set. Supported uncorrectable bits are 4, 5, 12 to 24 and 26. Supported correctable bits are 0, 6, 7, 8, 12, 13, 14 and 15. An illegal event changes no register and produces no message and no record request.
- R2: Uncorrectable bits 4, 5, 13, 17, 18 and 22 are fatal by default, and every other uncorrectable bit is non-fatal. The severity register (wr_sel 2) resets to this pattern, a 1 in it means fatal, and software may overwrite it.
- R3: Device status bits are: bit0 correctable detected, bit1 non-fatal detected, bit2 fatal detected, bit3 unsupported request detected. A legal correctable event sets bit0. A legal uncorrectable event sets bit2 or bit1 according to its severity. Uncorrectable bit 20 (unsupported request) also sets bit3.
- R4: A legal correctable event always sets its correctable status bit. If its correctable mask bit (wr_sel 4) is set, no message is sent.
- R5: A legal uncorrectable event always sets its uncorrectable status bit. If its mask bit (wr_sel 1) is set, the event makes no record request and sends no message. If the mask bit is clear, rec_req is high in the event's own cycle.
- R6: A non-fatal uncorrectable event that carries the advisory flag is handled as correctable. It sets device status bit0 (and bit3 for bit 20) and correctable status bit 13. If correctable mask bit 13 is set, nothing else happens. Otherwise the uncorrectable status bit is set, a record is requested when that bit is unmasked, and any message has correctable severity.
- R7: The enable register (wr_sel 6) holds bit0 correctable-report, bit1 non-fatal-report, bit2 fatal-report, bit3 UR-report and bit4 SERR. A correctable message needs bit0. An advisory unsupported-request event also needs bit3.
- R8: A fatal message needs SERR or fatal-report. A non-fatal message needs SERR or non-fatal-report. An uncorrectable unsupported request is dropped when both UR-report and SERR are clear.
- R9: If rec_overflow is high while rec_req is high, the block later injects a correctable event on bit 15 (header log overflow). The injection happens in the first following cycle with evt_valid low, and the event carries the source ID of the event that overflowed.
- R10: A message appears on msg_valid for one cycle, in the cycle after the event. msg_sev is one-hot with bit2 fatal, bit1 non-fatal and bit0 correctable. msg_src carries the event's source ID. msg_sev and msg_src are zero when no message is sent.
- R11: The status registers use write-1-to-clear on wr_sel 0 (uncorrectable), 3 (correctable) and 5 (device). When a set and a clear of the same bit happen in one cycle, the set wins. Writes to wr_sel 7 have no effect. After reset all registers are zero except severity.
- R12: While rec_req is high, rec_status holds the event status after supported masking and rec_src holds its source ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_status | input | 32 | Error status vector, expected one-hot |
| evt_uncor | input | 1 | 1 = uncorrectable class |
| evt_advisory | input | 1 | Event may be handled as advisory |
| evt_src | input | 16 | Requester source ID |
| rec_overflow | input | 1 | Log keeper full, same cycle as rec_req |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| rec_req | output | 1 | Record request pulse |
| rec_status | output | 32 | Status bit to record |
| rec_src | output | 16 | Source ID to record |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 3 | One-hot message severity |
| msg_src | output | 16 | Message source ID |
| uncor_status | output | 32 | Uncorrectable status register |
| cor_status | output | 32 | Correctable status register |
| dev_status | output | 4 | Device error summary |

## Verification
The same fatal and non-fatal status bits are sent under different severity settings, which separates the default severity pattern from a programmed override. Masked, unmasked and advisory versions of one error type show whether the record, status and message paths are controlled separately. Each enable bit is toggled on its own, so SERR acting as a substitute can be told apart from the per-severity report enables. A long random stream of legal, multi-bit and unsupported statuses, mixed with writes and overflow answers, is compared cycle by cycle against a behavioural model in the bench. That stream exercises deferred overflow injection while external events are arriving.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;
    localparam int ERR_W = 32;
    localparam int SRC_W = 16;
    localparam int DEV_W = 4;
    localparam int EN_W  = 5;
    localparam int SEL_W = 3;

    localparam logic [ERR_W-1:0] UNC_SUPPORTED   = 32'h05FF_F030;
    localparam logic [ERR_W-1:0] COR_SUPPORTED   = 32'h0000_F1C1;
    localparam logic [ERR_W-1:0] UNC_SEV_DEFAULT = 32'h0046_2030;

    localparam int UR_IDX  = 20;
    localparam int ADV_IDX = 13;
    localparam int HLO_IDX = 15;

    localparam int DEV_COR = 0;
    localparam int DEV_NF  = 1;
    localparam int DEV_FAT = 2;
    localparam int DEV_UR  = 3;

    localparam logic [2:0] SEV_COR = 3'b001;
    localparam logic [2:0] SEV_NF  = 3'b010;
    localparam logic [2:0] SEV_FAT = 3'b100;

    typedef enum logic [SEL_W-1:0] {
        SEL_UNC_STAT = 3'd0,
        SEL_UNC_MASK = 3'd1,
        SEL_UNC_SEV  = 3'd2,
        SEL_COR_STAT = 3'd3,
        SEL_COR_MASK = 3'd4,
        SEL_DEV_STAT = 3'd5,
        SEL_ENABLE   = 3'd6,
        SEL_NONE     = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic serr;
        logic ur;
        logic fat;
        logic nf;
        logic cor;
    } enables_t;

    typedef struct packed {
        logic             valid;
        logic             uncor;
        logic             adv;
        logic [SRC_W-1:0] src;
        logic [ERR_W-1:0] status;
    } err_evt_t;

    typedef struct packed {
        logic [ERR_W-1:0] unc_set;
        logic [ERR_W-1:0] cor_set;
        logic [DEV_W-1:0] dev_set;
        logic             rec;
        logic             msg;
        logic [2:0]       sev;
        logic [ERR_W-1:0] rec_status;
    } err_act_t;

    function automatic logic single_bit(input logic [ERR_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/sticky_w1c.sv
module sticky_w1c #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_en ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_eff) | set;
    end
endmodule

// File: rtl/err_regfile.sv
module err_regfile
    import err_sig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] unc_set,
    input  logic [ERR_W-1:0] cor_set,
    input  logic [DEV_W-1:0] dev_set,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [ERR_W-1:0] wr_data,
    output logic [ERR_W-1:0] unc_stat,
    output logic [ERR_W-1:0] cor_stat,
    output logic [DEV_W-1:0] dev_stat,
    output logic [ERR_W-1:0] unc_mask,
    output logic [ERR_W-1:0] unc_sev,
    output logic [ERR_W-1:0] cor_mask,
    output enables_t         en
);
    reg_sel_e sel;
    logic [EN_W-1:0] en_q;
    assign sel = reg_sel_e'(wr_sel);
    assign en  = enables_t'(en_q);

    sticky_w1c #(.W(ERR_W)) u_unc_stat (
        .clk(clk), .rst(rst), .set(unc_set),
        .clr_en(wr_en && sel == SEL_UNC_STAT), .clr(wr_data), .q(unc_stat));
    sticky_w1c #(.W(ERR_W)) u_cor_stat (
        .clk(clk), .rst(rst), .set(cor_set),
        .clr_en(wr_en && sel == SEL_COR_STAT), .clr(wr_data), .q(cor_stat));
    sticky_w1c #(.W(DEV_W)) u_dev_stat (
        .clk(clk), .rst(rst), .set(dev_set),
        .clr_en(wr_en && sel == SEL_DEV_STAT), .clr(wr_data[DEV_W-1:0]), .q(dev_stat));

    always_ff @(posedge clk) begin
        if (rst) begin
            unc_mask <= '0;
            unc_sev  <= UNC_SEV_DEFAULT;
            cor_mask <= '0;
            en_q     <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_UNC_MASK: unc_mask <= wr_data;
                SEL_UNC_SEV:  unc_sev  <= wr_data;
                SEL_COR_MASK: cor_mask <= wr_data;
                SEL_ENABLE:   en_q     <= wr_data[EN_W-1:0];
                default: ;
            endcase
        end
    end

    // R11: uncorrectable status bits stay set unless software clears them
    p_sticky_unc_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_UNC_STAT) |=> ((unc_stat & $past(unc_stat)) == $past(unc_stat)));
    // R11: correctable status bits stay set unless software clears them
    p_sticky_cor_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_COR_STAT) |=> ((cor_stat & $past(cor_stat)) == $past(cor_stat)));
endmodule

// File: rtl/err_classify.sv
module err_classify
    import err_sig_pkg::*;
(
    input  logic             valid,
    input  logic             uncor,
    input  logic             adv,
    input  logic [ERR_W-1:0] status,
    input  logic [ERR_W-1:0] unc_mask,
    input  logic [ERR_W-1:0] unc_sev,
    input  logic [ERR_W-1:0] cor_mask,
    input  enables_t         en,
    output err_act_t         act
);
    logic [ERR_W-1:0] s;
    logic legal, fatal, is_ur, unc_open;

    always_comb begin
        s        = status & (uncor ? UNC_SUPPORTED : COR_SUPPORTED);
        legal    = valid && single_bit(s);
        fatal    = |(s & unc_sev);
        is_ur    = uncor && s[UR_IDX];
        unc_open = !(|(s & unc_mask));
        act            = '0;
        act.rec_status = s;
        if (legal) begin
            if (!uncor) begin
                act.dev_set[DEV_COR] = 1'b1;
                act.cor_set          = s;
                if (!(|(s & cor_mask)) && en.cor) begin
                    act.msg = 1'b1;
                    act.sev = SEV_COR;
                end
            end else if (!fatal && adv) begin
                act.dev_set[DEV_COR]  = 1'b1;
                act.dev_set[DEV_UR]   = is_ur;
                act.cor_set[ADV_IDX]  = 1'b1;
                if (!cor_mask[ADV_IDX]) begin
                    act.unc_set = s;
                    act.rec     = unc_open;
                    if (en.cor && (!is_ur || en.ur)) begin
                        act.msg = 1'b1;
                        act.sev = SEV_COR;
                    end
                end
            end else begin
                act.dev_set[DEV_FAT] = fatal;
                act.dev_set[DEV_NF]  = !fatal;
                act.dev_set[DEV_UR]  = is_ur;
                act.unc_set          = s;
                if (unc_open) begin
                    act.rec = 1'b1;
                    if ((!is_ur || en.ur || en.serr) &&
                        (en.serr || (fatal ? en.fat : en.nf))) begin
                        act.msg = 1'b1;
                        act.sev = fatal ? SEV_FAT : SEV_NF;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/err_signal.sv
module err_signal
    import err_sig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [ERR_W-1:0] evt_status,
    input  logic             evt_uncor,
    input  logic             evt_advisory,
    input  logic [SRC_W-1:0] evt_src,
    input  logic             rec_overflow,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [ERR_W-1:0] wr_data,
    output logic             rec_req,
    output logic [ERR_W-1:0] rec_status,
    output logic [SRC_W-1:0] rec_src,
    output logic             msg_valid,
    output logic [2:0]       msg_sev,
    output logic [SRC_W-1:0] msg_src,
    output logic [ERR_W-1:0] uncor_status,
    output logic [ERR_W-1:0] cor_status,
    output logic [DEV_W-1:0] dev_status
);
    err_evt_t         cur;
    err_act_t         act;
    logic             ovf_pend;
    logic [SRC_W-1:0] ovf_src;
    logic [ERR_W-1:0] unc_mask, unc_sev, cor_mask;
    enables_t         en;

    always_comb begin
        cur = '0;
        if (evt_valid) begin
            cur.valid  = 1'b1;
            cur.uncor  = evt_uncor;
            cur.adv    = evt_advisory;
            cur.src    = evt_src;
            cur.status = evt_status;
        end else if (ovf_pend) begin
            cur.valid  = 1'b1;
            cur.src    = ovf_src;
            cur.status = ERR_W'(1) << HLO_IDX;
        end
    end

    err_classify u_classify (
        .valid(cur.valid), .uncor(cur.uncor), .adv(cur.adv), .status(cur.status),
        .unc_mask(unc_mask), .unc_sev(unc_sev), .cor_mask(cor_mask), .en(en),
        .act(act));

    err_regfile u_regs (
        .clk(clk), .rst(rst),
        .unc_set(act.unc_set), .cor_set(act.cor_set), .dev_set(act.dev_set),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .unc_stat(uncor_status), .cor_stat(cor_status), .dev_stat(dev_status),
        .unc_mask(unc_mask), .unc_sev(unc_sev), .cor_mask(cor_mask), .en(en));

    assign rec_req    = act.rec;
    assign rec_status = act.rec ? act.rec_status : '0;
    assign rec_src    = evt_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_pend  <= 1'b0;
            ovf_src   <= '0;
            msg_valid <= 1'b0;
            msg_sev   <= '0;
            msg_src   <= '0;
        end else begin
            if (act.rec && rec_overflow) begin
                ovf_pend <= 1'b1;
                ovf_src  <= evt_src;
            end else if (!evt_valid && ovf_pend) begin
                ovf_pend <= 1'b0;
            end
            msg_valid <= act.msg;
            msg_sev   <= act.msg ? act.sev : 3'b000;
            msg_src   <= act.msg ? cur.src : '0;
        end
    end

    // R10: a message always carries exactly one severity
    p_sev_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $onehot(msg_sev));
    // R1: an illegal external event gives no message in the next cycle
    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && $countones(evt_status & (evt_uncor ? UNC_SUPPORTED : COR_SUPPORTED)) != 1)
        |=> !msg_valid);
    // R5: record requests come only from external uncorrectable events
    p_rec_uncor_r5: assert property (@(posedge clk) disable iff (rst)
        rec_req |-> (evt_valid && evt_uncor));
    // R9: an overflow followed by an idle input cycle leaves the overflow bit set
    p_hlo_follow_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rec_req && rec_overflow) && !evt_valid) |=> cor_status[HLO_IDX]);
endmodule

// File: tb/err_signal_tb.sv
module err_signal_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 0, i_uncor = 0, i_adv = 0, i_ovf = 0, i_wen = 0;
    logic [31:0] i_status = 0, i_wdata = 0;
    logic [15:0] i_src = 0;
    logic [2:0]  i_wsel = 0;

    logic        rec_req, msg_valid;
    logic [31:0] rec_status, uncor_status, cor_status;
    logic [15:0] rec_src, msg_src;
    logic [2:0]  msg_sev;
    logic [3:0]  dev_status;

    int    checks = 0, failures = 0;
    string cur_req = "R11";
    bit    done = 0;

    // bench-side model state
    logic [31:0] m_unc_st, m_cor_st, m_unc_mask, m_sev, m_cor_mask;
    logic [3:0]  m_dev;
    logic [4:0]  m_en;
    bit          m_pend;
    logic [15:0] m_psrc;
    bit          e_mv;
    logic [2:0]  e_ms;
    logic [15:0] e_msrc;

    localparam logic [31:0] UNC_SUP = 32'h05FF_F030;
    localparam logic [31:0] COR_SUP = 32'h0000_F1C1;

    always #5 clk = ~clk;

    err_signal u_dut (
        .clk(clk), .rst(rst), .evt_valid(i_valid), .evt_status(i_status),
        .evt_uncor(i_uncor), .evt_advisory(i_adv), .evt_src(i_src),
        .rec_overflow(i_ovf), .wr_en(i_wen), .wr_sel(i_wsel), .wr_data(i_wdata),
        .rec_req(rec_req), .rec_status(rec_status), .rec_src(rec_src),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
        .uncor_status(uncor_status), .cor_status(cor_status), .dev_status(dev_status));

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_unc_st = 0; m_cor_st = 0; m_dev = 0; m_unc_mask = 0; m_cor_mask = 0;
        m_sev = 32'h0046_2030; m_en = 0; m_pend = 0; m_psrc = 0;
        e_mv = 0; e_ms = 0; e_msrc = 0;
    endtask

    task automatic compare_regs();
        chk("msg_valid", 32'(msg_valid), 32'(e_mv));
        chk("msg_sev", 32'(msg_sev), 32'(e_ms));
        chk("msg_src", 32'(msg_src), 32'(e_msrc));
        chk("uncor_status", uncor_status, m_unc_st);
        chk("cor_status", cor_status, m_cor_st);
        chk("dev_status", 32'(dev_status), 32'(m_dev));
    endtask

    task automatic model_step();
        logic [31:0] s = 0, us = 0, cs = 0, cu = 0, cc = 0;
        logic [3:0]  ds = 0, cd = 0;
        logic        u = 0, a = 0, vld = 0;
        logic [15:0] src = 0;
        bit fat, ur, rec = 0, m = 0;
        logic [2:0] sv = 0;
        int n = 0;
        if (i_valid) begin
            vld = 1; s = i_status; u = i_uncor; a = i_adv; src = i_src;
        end else if (m_pend) begin
            vld = 1; s = 32'h1 << 15; src = m_psrc; m_pend = 0;
        end
        if (vld) begin
            s = s & (u ? UNC_SUP : COR_SUP);
            for (int k = 0; k < 32; k++) if (s[k]) n++;
            if (n == 1) begin
                if (!u) begin
                    ds[0] = 1; cs = s;
                    if ((s & m_cor_mask) == 0 && m_en[0]) begin m = 1; sv = 3'b001; end
                end else begin
                    fat = (s & m_sev) != 0;
                    ur  = (s == (32'h1 << 20));
                    if (!fat && a) begin
                        ds[0] = 1; if (ur) ds[3] = 1; cs[13] = 1;
                        if (!m_cor_mask[13]) begin
                            us = s; rec = ((s & m_unc_mask) == 0);
                            if (m_en[0] && (!ur || m_en[3])) begin m = 1; sv = 3'b001; end
                        end
                    end else begin
                        if (fat) ds[2] = 1; else ds[1] = 1;
                        if (ur) ds[3] = 1;
                        us = s;
                        if ((s & m_unc_mask) == 0) begin
                            rec = 1;
                            if (ur && !m_en[3] && !m_en[4]) m = 0;
                            else if (m_en[4] || (fat ? m_en[2] : m_en[1])) begin
                                m = 1; sv = fat ? 3'b100 : 3'b010;
                            end
                        end
                    end
                end
            end
        end
        // R12 / R5: combinational record interface in this cycle
        chk("rec_req", 32'(rec_req), 32'(rec));
        if (rec) begin
            chk("rec_status R12", rec_status, s);
            chk("rec_src R12", 32'(rec_src), 32'(i_src));
        end
        if (rec && i_ovf) begin m_pend = 1; m_psrc = i_src; end
        if (i_wen) begin
            case (i_wsel)
                3'd0: cu = i_wdata;
                3'd1: m_unc_mask = i_wdata;
                3'd2: m_sev = i_wdata;
                3'd3: cc = i_wdata;
                3'd4: m_cor_mask = i_wdata;
                3'd5: cd = i_wdata[3:0];
                3'd6: m_en = i_wdata[4:0];
                default: ;
            endcase
        end
        m_unc_st = (m_unc_st & ~cu) | us;
        m_cor_st = (m_cor_st & ~cc) | cs;
        m_dev    = (m_dev & ~cd) | ds;
        e_mv = m; e_ms = sv; e_msrc = m ? src : 16'h0;
    endtask

    task automatic cyc(input logic v, input logic [31:0] st, input logic u, input logic a,
                       input logic [15:0] src, input logic ovf,
                       input logic wen, input logic [2:0] sel, input logic [31:0] data);
        i_valid = v; i_status = st; i_uncor = u; i_adv = a; i_src = src; i_ovf = ovf;
        i_wen = wen; i_wsel = sel; i_wdata = data;
        #1;
        model_step();
        @(negedge clk);
        compare_regs();
    endtask

    task automatic ev(input logic [31:0] st, input logic u, input logic a, input logic [15:0] src);
        cyc(1, st, u, a, src, 0, 0, 0, 0);
    endtask
    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        cyc(0, 0, 0, 0, 0, 0, 1, sel, data);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        model_reset();
        cur_req = "R11"; compare_regs();

        cur_req = "R1";
        ev(32'h30, 1, 0, 16'h0101); ev(32'h1, 1, 0, 16'h0102);
        ev(32'h10, 0, 0, 16'h0103); ev(32'h0, 0, 0, 16'h0104); idle();

        cur_req = "R3";
        ev(32'h1 << 6, 0, 0, 16'h0011);
        cur_req = "R7";
        wr(6, 32'h1); ev(32'h1, 0, 0, 16'h0022); idle();

        cur_req = "R4";
        wr(4, 32'h1 << 7); ev(32'h1 << 7, 0, 0, 16'h0023); idle();

        cur_req = "R2";
        ev(32'h1 << 4, 1, 0, 16'h0031);
        wr(6, 32'h5); ev(32'h1 << 5, 1, 0, 16'h0033);
        cur_req = "R8";
        ev(32'h1 << 12, 1, 0, 16'h0034);
        wr(6, 32'h11); ev(32'h1 << 12, 1, 0, 16'h0035);
        cur_req = "R2";
        wr(2, 32'h0); ev(32'h1 << 4, 1, 0, 16'h0036);
        wr(2, 32'h1 << 12); ev(32'h1 << 12, 1, 0, 16'h0037); idle();

        cur_req = "R5";
        wr(1, 32'h1 << 14); ev(32'h1 << 14, 1, 0, 16'h0041);
        ev(32'h1 << 16, 1, 0, 16'h0042); idle();

        cur_req = "R6";
        wr(6, 32'h1);
        ev(32'h1 << 15, 1, 1, 16'h0051); ev(32'h1 << 14, 1, 1, 16'h0052);
        ev(32'h1 << 12, 1, 1, 16'h0053);
        wr(4, 32'h1 << 13); ev(32'h1 << 16, 1, 1, 16'h0054); wr(4, 32'h0); idle();

        cur_req = "R7";
        ev(32'h1 << 20, 1, 1, 16'h0061);
        wr(6, 32'h9); ev(32'h1 << 20, 1, 1, 16'h0062); idle();

        cur_req = "R8";
        wr(6, 32'h2); ev(32'h1 << 20, 1, 0, 16'h0071);
        wr(6, 32'h10); ev(32'h1 << 20, 1, 0, 16'h0072);
        wr(6, 32'ha); ev(32'h1 << 20, 1, 0, 16'h0073); idle();

        cur_req = "R9";
        wr(6, 32'h1);
        cyc(1, 32'h1 << 17, 1, 0, 16'h0077, 1, 0, 0, 0);
        ev(32'h1, 0, 0, 16'h0088);
        idle(); idle();
        cyc(1, 32'h1 << 18, 1, 0, 16'h0099, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 4, 32'h1 << 15);
        idle(); wr(4, 32'h0);

        cur_req = "R11";
        wr(0, 32'hFFFF_FFFF);
        cyc(1, 32'h1, 0, 0, 16'h00AA, 0, 1, 3, 32'hFFFF_FFFF);
        wr(5, 32'hF); wr(7, 32'hFFFF_FFFF); idle();

        cur_req = "R12";
        ev(32'h8001_0001, 1, 0, 16'h00BB); idle();

        cur_req = "R10";
        for (int t = 0; t < 3000; t++) begin
            logic [31:0] st;
            logic v, u, w;
            v = ($urandom % 2) == 0;
            u = $urandom % 2;
            st = (($urandom % 4) == 0) ? $urandom : (32'h1 << ($urandom % 32));
            w = ($urandom % 4) == 0;
            cyc(v, st, u, 1'($urandom % 2), 16'($urandom), 1'(($urandom % 5) == 0),
                w, 3'($urandom % 8), (($urandom % 2) == 0) ? $urandom : (32'h1 << ($urandom % 32)));
        end
        idle(); idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule